// File: doc/BRIEF.md
# Extended Parameter Page ECC Parser

This block takes the bytes of an extended flash parameter page as a stream and works out the ECC requirement that the page describes. A `start` pulse gives the page length in 16-byte units. The block then accepts that many bytes on `in_valid`/`in_byte` and writes them into an internal page buffer. While the bytes arrive, it runs the page checksum over them. Once the last byte has arrived, it checks the signature and walks the section descriptor table in the buffer. This finds the section that carries ECC information, and the block takes the correction strength and the codeword size exponent from it.

Every accepted `start` produces exactly one `done` pulse. In the same cycle as that pulse, `valid` or `error` is set. When the outcome is valid, `ecc_strength` and `step_log2` hold the result. The codeword step in bytes is 2 to the power `step_log2`. The outputs keep their values until the next accepted `start`. A host issues the read of the page on the flash bus and forwards the data bytes. This block only consumes those bytes.

Top module: `epp_ecc_parser`

## Requirements
- R1: A page is `len_units` × 16 bytes long. A `start` is accepted only when `len_units` is between 2 and `MAX_UNITS` (default 32). Any other length produces a `done` pulse with `error` set, and no bytes are consumed.
- R2: The checksum is a 16-bit CRC with polynomial 0x8005, processed MSB-first and seeded with 0x4F4E. It runs over page bytes 2 through the last byte. It is compared with the little-endian value in bytes 0 (low) and 1 (high), and a mismatch sets `error`.
- R3: Bytes 2, 3, 4 and 5 must hold the ASCII characters 'E', 'P', 'P', 'S' in that order. Any other content sets `error`.
- R4: The descriptor table has 8 entries of two bytes each, starting at byte 16. Entry i has its type at byte 16+2i and its length, in 16-byte units, at byte 17+2i. The data cursor starts at byte 32. Entries are examined in order and the first entry of type 2 is used. Each entry skipped before it moves the cursor forward by 16 × its length, and later type-2 entries are ignored.
- R5: If none of the 8 entries has type 2, `error` is set.
- R6: In the ECC section, the byte at the cursor is the strength and the next byte is the codeword exponent. An exponent of zero sets `error`. So does an ECC section that starts at or beyond the end of the page. Otherwise `valid` is set, `ecc_strength` gets the strength and `step_log2` gets the exponent.
- R7: `done` lasts one cycle, and `valid` and `error` are never high together. `valid`, `error`, `ecc_strength` and `step_log2` change only in the cycle of a `done` pulse, with one exception: an accepted `start` clears `valid` and `error`.
- R8: A `start` that arrives while a page is still being captured or parsed is ignored. Bytes offered while no capture is in progress are also ignored.
- R9: After a synchronous reset, `done`, `valid` and `error` are low, and `ecc_strength` and `step_log2` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new page; sampled only while idle |
| len_units | input | LEN_W (16) | Page length in 16-byte units, sampled with `start` |
| in_valid | input | 1 | Page byte present on `in_byte` |
| in_byte | input | 8 | Page data, byte 0 first |
| done | output | 1 | One-cycle pulse when the result is ready |
| valid | output | 1 | Last page parsed successfully |
| error | output | 1 | Last page rejected |
| ecc_strength | output | 8 | Required correction strength in bits |
| step_log2 | output | 8 | Codeword size as a power-of-two exponent |

## Verification
The bound checker watches the interface rules on every cycle:
- `done` is a single-cycle pulse.
- `valid` and `error` are never high together.
- `valid`, `error` and the result fields rise or change only alongside `done`.
- A valid result never carries a zero exponent.
- The reset values are correct.

Whether a particular page gives the right verdict can only come from the bench's scenarios. These cover checksum and signature damage, the cursor arithmetic over skipped sections of varied and zero length, a first-match choice when later entries also have type 2, a missing ECC entry, and an ECC section just inside or just past the page end. They also cover illegal lengths, a `start` arriving in mid-capture, and stray bytes sent while the block is idle.

// File: rtl/epp_pkg.sv
package epp_pkg;

  localparam int UNIT_BYTES  = 16;
  localparam int SIG_OFFSET  = 2;
  localparam int TBL_BASE    = 16;
  localparam int TBL_ENTRIES = 8;
  localparam int DATA_BASE   = 32;

  localparam logic [15:0] CRC_SEED = 16'h4F4E;
  localparam logic [15:0] CRC_POLY = 16'h8005;
  localparam logic [31:0] SIG_WORD = 32'h45505053; // 'E','P','P','S'
  localparam logic [7:0]  ECC_TYPE = 8'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_USE,
    ST_FIN
  } scan_st_t;

  typedef enum logic [2:0] {
    PH_SIG,
    PH_TYPE,
    PH_LEN,
    PH_STR,
    PH_CW
  } phase_t;

  function automatic logic [15:0] crc_byte(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    c = c_in ^ {d, 8'h00};
    for (int b = 0; b < 8; b++) begin
      c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [7:0] sig_byte(input logic [1:0] idx);
    return SIG_WORD[31 - 8*idx -: 8];
  endfunction

endpackage

// File: rtl/epp_page_ram.sv
module epp_page_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/epp_capture.sv
module epp_capture
  import epp_pkg::*;
#(
  parameter int MAX_UNITS = 32,
  parameter int LEN_W     = 16,
  parameter int AW        = 9,
  parameter int CNT_W     = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len_units,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             release_i,
  output logic             accepted,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output logic [CNT_W-1:0] page_bytes,
  output logic             cap_done,
  output logic             cap_ok
);

  logic             busy_r;
  logic             cap_r;
  logic [CNT_W-1:0] cnt_r;
  logic [CNT_W-1:0] total_r;
  logic [15:0]      crc_r;
  logic [15:0]      crc_next;
  logic [7:0]       ref_lo_r;
  logic [7:0]       ref_hi_r;
  logic             len_good;
  logic             last_byte;

  assign accepted  = start && !busy_r;
  assign len_good  = (len_units >= LEN_W'(2)) && (len_units <= LEN_W'(MAX_UNITS));
  assign crc_next  = crc_byte(crc_r, in_byte);
  assign last_byte = (cnt_r == total_r - CNT_W'(1));

  assign wr_en      = cap_r && in_valid;
  assign wr_addr    = AW'(cnt_r);
  assign wr_data    = in_byte;
  assign page_bytes = total_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_r   <= 1'b0;
      cap_r    <= 1'b0;
      cnt_r    <= '0;
      total_r  <= '0;
      crc_r    <= CRC_SEED;
      ref_lo_r <= '0;
      ref_hi_r <= '0;
      cap_done <= 1'b0;
      cap_ok   <= 1'b0;
    end else begin
      cap_done <= 1'b0;
      if (release_i) busy_r <= 1'b0;
      if (accepted) begin
        busy_r <= 1'b1;
        cnt_r  <= '0;
        crc_r  <= CRC_SEED;
        if (len_good) begin
          cap_r   <= 1'b1;
          total_r <= {len_units[CNT_W-5:0], 4'b0000};
        end else begin
          cap_r    <= 1'b0;
          total_r  <= '0;
          cap_done <= 1'b1;
          cap_ok   <= 1'b0;
        end
      end else if (cap_r && in_valid) begin
        cnt_r <= cnt_r + CNT_W'(1);
        if (cnt_r == CNT_W'(0)) ref_lo_r <= in_byte;
        if (cnt_r == CNT_W'(1)) ref_hi_r <= in_byte;
        if (cnt_r >= CNT_W'(2)) crc_r <= crc_next;
        if (last_byte) begin
          cap_r    <= 1'b0;
          cap_done <= 1'b1;
          cap_ok   <= (crc_next == {ref_hi_r, ref_lo_r});
        end
      end
    end
  end

endmodule

// File: rtl/epp_scan.sv
module epp_scan
  import epp_pkg::*;
#(
  parameter int AW    = 9,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cap_done,
  input  logic             cap_ok,
  input  logic [CNT_W-1:0] page_bytes,
  input  logic [7:0]       rd_data,
  output logic [AW-1:0]    rd_addr,
  output logic             done,
  output logic             valid,
  output logic             error,
  output logic [7:0]       strength,
  output logic [7:0]       step_log2
);

  localparam int KW = $clog2(TBL_ENTRIES);

  scan_st_t      st_r;
  phase_t        ph_r;
  logic [KW-1:0] k_r;
  logic [15:0]   cursor_r;
  logic [7:0]    str_r;
  logic [7:0]    cw_r;
  logic          ok_r;
  logic [16:0]   cw_pos;
  logic          in_page;

  assign cw_pos  = {1'b0, cursor_r} + 17'd1;
  assign in_page = cw_pos < 17'(page_bytes);

  always_comb begin
    unique case (ph_r)
      PH_SIG:  rd_addr = AW'(SIG_OFFSET) + AW'(k_r);
      PH_TYPE: rd_addr = AW'(TBL_BASE) + AW'({k_r, 1'b0});
      PH_LEN:  rd_addr = AW'(TBL_BASE + 1) + AW'({k_r, 1'b0});
      PH_STR:  rd_addr = AW'(cursor_r);
      default: rd_addr = AW'(cw_pos);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_r      <= ST_IDLE;
      ph_r      <= PH_SIG;
      k_r       <= '0;
      cursor_r  <= 16'(DATA_BASE);
      str_r     <= '0;
      cw_r      <= '0;
      ok_r      <= 1'b0;
      done      <= 1'b0;
      valid     <= 1'b0;
      error     <= 1'b0;
      strength  <= '0;
      step_log2 <= '0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        valid <= 1'b0;
        error <= 1'b0;
      end
      unique case (st_r)
        ST_IDLE: begin
          if (cap_done) begin
            ph_r     <= PH_SIG;
            k_r      <= '0;
            cursor_r <= 16'(DATA_BASE);
            if (cap_ok) begin
              st_r <= ST_ISSUE;
            end else begin
              ok_r <= 1'b0;
              st_r <= ST_FIN;
            end
          end
        end
        ST_ISSUE: st_r <= ST_USE;
        ST_USE: begin
          st_r <= ST_ISSUE;
          unique case (ph_r)
            PH_SIG: begin
              if (rd_data != sig_byte(k_r[1:0])) begin
                ok_r <= 1'b0;
                st_r <= ST_FIN;
              end else if (k_r == KW'(3)) begin
                ph_r <= PH_TYPE;
                k_r  <= '0;
              end else begin
                k_r <= k_r + KW'(1);
              end
            end
            PH_TYPE: begin
              if (rd_data == ECC_TYPE) begin
                if (in_page) begin
                  ph_r <= PH_STR;
                end else begin
                  ok_r <= 1'b0;
                  st_r <= ST_FIN;
                end
              end else begin
                ph_r <= PH_LEN;
              end
            end
            PH_LEN: begin
              cursor_r <= cursor_r + {4'd0, rd_data, 4'd0};
              if (k_r == KW'(TBL_ENTRIES - 1)) begin
                ok_r <= 1'b0;
                st_r <= ST_FIN;
              end else begin
                k_r  <= k_r + KW'(1);
                ph_r <= PH_TYPE;
              end
            end
            PH_STR: begin
              str_r <= rd_data;
              ph_r  <= PH_CW;
            end
            default: begin
              cw_r <= rd_data;
              ok_r <= (rd_data != 8'd0);
              st_r <= ST_FIN;
            end
          endcase
        end
        default: begin
          done  <= 1'b1;
          valid <= ok_r;
          error <= !ok_r;
          if (ok_r) begin
            strength  <= str_r;
            step_log2 <= cw_r;
          end
          st_r <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/epp_ecc_parser.sv
module epp_ecc_parser
  import epp_pkg::*;
#(
  parameter int MAX_UNITS = 32,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len_units,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             done,
  output logic             valid,
  output logic             error,
  output logic [7:0]       ecc_strength,
  output logic [7:0]       step_log2
);

  localparam int DEPTH = MAX_UNITS * UNIT_BYTES;
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  logic             accepted;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [7:0]       wr_data;
  logic [AW-1:0]    rd_addr;
  logic [7:0]       rd_data;
  logic [CNT_W-1:0] page_bytes;
  logic             cap_done;
  logic             cap_ok;

  epp_capture #(
    .MAX_UNITS(MAX_UNITS),
    .LEN_W    (LEN_W),
    .AW       (AW),
    .CNT_W    (CNT_W)
  ) u_capture (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .len_units (len_units),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .release_i (done),
    .accepted  (accepted),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .page_bytes(page_bytes),
    .cap_done  (cap_done),
    .cap_ok    (cap_ok)
  );

  epp_page_ram #(
    .DEPTH(DEPTH),
    .AW   (AW)
  ) u_ram (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(wr_data),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  epp_scan #(
    .AW   (AW),
    .CNT_W(CNT_W)
  ) u_scan (
    .clk       (clk),
    .rst       (rst),
    .clr       (accepted),
    .cap_done  (cap_done),
    .cap_ok    (cap_ok),
    .page_bytes(page_bytes),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .done      (done),
    .valid     (valid),
    .error     (error),
    .strength  (ecc_strength),
    .step_log2 (step_log2)
  );

endmodule

// File: rtl/epp_ecc_parser_chk.sv
module epp_ecc_parser_chk (
  input logic       clk,
  input logic       rst,
  input logic       done,
  input logic       valid,
  input logic       error,
  input logic [7:0] ecc_strength,
  input logic [7:0] step_log2
);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> !error);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(ecc_strength) && $stable(step_log2)));

  // R7
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> done);

  // R7
  error_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> done);

  // R6
  step_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (step_log2 != 8'd0));

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!done && !valid && !error && ecc_strength == 8'd0 && step_log2 == 8'd0));

endmodule

bind epp_ecc_parser epp_ecc_parser_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .done        (done),
  .valid       (valid),
  .error       (error),
  .ecc_strength(ecc_strength),
  .step_log2   (step_log2)
);

// File: tb/epp_ecc_parser_tb.sv
module epp_ecc_parser_tb;

  localparam int MAX_UNITS = 32;
  localparam int PAGE_MAX  = MAX_UNITS * 16;
  localparam int NV        = 13;

  typedef struct packed {
    logic [7:0]  req;
    logic [15:0] units;
    logic [7:0]  nskip;
    logic [7:0]  slen;
    logic [7:0]  str;
    logic [7:0]  cw;
    logic [1:0]  corrupt;  // 1: checksum, 2: signature
    logic        gap;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'd4, 16'd4,  8'd0, 8'd0, 8'd8,  8'd9,  2'd0, 1'b0}, // R4 first entry
    '{8'd4, 16'd8,  8'd2, 8'd1, 8'd24, 8'd10, 2'd0, 1'b1}, // R4 two skipped
    '{8'd4, 16'd32, 8'd7, 8'd3, 8'd40, 8'd11, 2'd0, 1'b0}, // R4 last entry
    '{8'd4, 16'd6,  8'd3, 8'd0, 8'd5,  8'd12, 2'd0, 1'b1}, // R4 zero-length skips
    '{8'd5, 16'd4,  8'd8, 8'd1, 8'd7,  8'd9,  2'd0, 1'b0}, // R5 no ECC entry
    '{8'd6, 16'd4,  8'd0, 8'd0, 8'd7,  8'd0,  2'd0, 1'b0}, // R6 zero exponent
    '{8'd2, 16'd4,  8'd0, 8'd0, 8'd7,  8'd9,  2'd1, 1'b0}, // R2 checksum damaged
    '{8'd3, 16'd4,  8'd0, 8'd0, 8'd7,  8'd9,  2'd2, 1'b0}, // R3 signature damaged
    '{8'd6, 16'd4,  8'd1, 8'd2, 8'd7,  8'd9,  2'd0, 1'b0}, // R6 section at page end
    '{8'd6, 16'd5,  8'd2, 8'd1, 8'd3,  8'd12, 2'd0, 1'b1}, // R6 section just inside
    '{8'd1, 16'd1,  8'd0, 8'd0, 8'd7,  8'd9,  2'd0, 1'b0}, // R1 too short
    '{8'd1, 16'd33, 8'd0, 8'd0, 8'd7,  8'd9,  2'd0, 1'b0}, // R1 too long
    '{8'd1, 16'd3,  8'd0, 8'd0, 8'd2,  8'd13, 2'd0, 1'b0}  // R1 small legal page
  };

  logic        clk;
  logic        rst;
  logic        start;
  logic [15:0] len_units;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        done;
  logic        valid;
  logic        error;
  logic [7:0]  ecc_strength;
  logic [7:0]  step_log2;

  int   n_checks = 0;
  int   n_errs   = 0;
  int   cycles   = 0;
  logic [7:0] page [PAGE_MAX];

  epp_ecc_parser #(.MAX_UNITS(MAX_UNITS), .LEN_W(16)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .len_units   (len_units),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .done        (done),
    .valid       (valid),
    .error       (error),
    .ecc_strength(ecc_strength),
    .step_log2   (step_log2)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_errs++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] bench_crc(input int total);
    logic [15:0] c = 16'h4F4E;
    for (int i = 2; i < total; i++) begin
      c = c ^ {page[i], 8'h00};
      for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
    end
    return c;
  endfunction

  task automatic build_page(input vec_t v, input int total);
    logic [15:0] c;
    int cur;
    for (int i = 0; i < total; i++) page[i] = 8'((i * 7 + 3) & 255);
    page[2] = 8'h45; page[3] = 8'h50; page[4] = 8'h50; page[5] = 8'h53;
    if (v.corrupt == 2'd2) page[4] = 8'h51;
    for (int j = 0; j < 8; j++) begin
      if (j < int'(v.nskip)) begin
        page[16 + 2*j] = (j % 3 == 0) ? 8'd1 : ((j % 3 == 1) ? 8'd3 : 8'd0);
        page[17 + 2*j] = v.slen;
      end else if (j == int'(v.nskip)) begin
        page[16 + 2*j] = 8'd2;
        page[17 + 2*j] = 8'd1;
      end else begin
        page[16 + 2*j] = 8'd2;   // later type-2 entries must be ignored
        page[17 + 2*j] = 8'd9;
      end
    end
    if (v.nskip < 8) begin
      cur = 32 + int'(v.nskip) * int'(v.slen) * 16;
      if (cur < total)     page[cur]     = v.str;
      if (cur + 1 < total) page[cur + 1] = v.cw;
    end
    c = bench_crc(total);
    page[0] = c[7:0];
    page[1] = c[15:8];
    if (v.corrupt == 2'd1) page[total - 1] = page[total - 1] ^ 8'h01;
  endtask

  task automatic run_vec(input vec_t v, input string tag, input bit poke);
    int  total;
    int  cur;
    bit  len_ok;
    bit  exp_ok;
    int  waited;
    total  = int'(v.units) * 16;
    len_ok = (v.units >= 2) && (v.units <= MAX_UNITS);
    cur    = 32 + int'(v.nskip) * int'(v.slen) * 16;
    exp_ok = len_ok && (v.corrupt == 2'd0) && (v.nskip < 8) && (cur < total) && (v.cw != 8'd0);
    if (len_ok) build_page(v, total);

    start     = 1'b1;
    len_units = v.units;
    @(negedge clk);
    start = 1'b0;
    // R7: accepted start clears the previous verdict
    chk("R7", {tag, " cleared valid"}, int'(valid), 0);
    chk("R7", {tag, " cleared error"}, int'(error), 0);

    if (len_ok) begin
      for (int i = 0; i < total; i++) begin
        if (poke && i == 100) begin
          // R8: start during capture must be ignored
          in_valid  = 1'b0;
          start     = 1'b1;
          len_units = 16'd1;
          @(negedge clk);
          start = 1'b0;
        end
        in_valid = 1'b1;
        in_byte  = page[i];
        @(negedge clk);
        if (v.gap && (i % 3 == 1)) begin
          in_valid = 1'b0;
          in_byte  = 8'hA5;
          @(negedge clk);
        end
      end
      in_valid = 1'b0;
    end

    waited = 0;
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    chk(tag, "done seen", int'(done), 1);
    chk(tag, "valid", int'(valid), int'(exp_ok));
    chk(tag, "error", int'(error), int'(!exp_ok));
    if (exp_ok) begin
      chk(tag, "strength", int'(ecc_strength), int'(v.str));
      chk(tag, "step_log2", int'(step_log2), int'(v.cw));
    end
    @(negedge clk);
    // R7: one-cycle pulse
    chk("R7", {tag, " done width"}, int'(done), 0);
  endtask

  initial begin
    rst       = 1'b1;
    start     = 1'b0;
    len_units = '0;
    in_valid  = 1'b0;
    in_byte   = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9", "done after reset", int'(done), 0);
    chk("R9", "valid after reset", int'(valid), 0);
    chk("R9", "error after reset", int'(error), 0);
    chk("R9", "strength after reset", int'(ecc_strength), 0);
    chk("R9", "step after reset", int'(step_log2), 0);

    for (int n = 0; n < NV; n++) begin
      run_vec(VECS[n], $sformatf("R%0d", VECS[n].req), 1'b0);
    end

    // R8: stray bytes while idle do not disturb the next page
    for (int i = 0; i < 40; i++) begin
      in_valid = 1'b1;
      in_byte  = 8'(i * 13);
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R8", "no done from idle bytes", int'(done), 0);
    run_vec(VECS[0], "R8", 1'b0);

    // R8: start arriving during capture is ignored
    run_vec(VECS[2], "R8", 1'b1);

    // R7: result held after done
    repeat (10) @(negedge clk);
    chk("R7", "valid held", int'(valid), 1);
    chk("R7", "strength held", int'(ecc_strength), 40);
    chk("R7", "no spurious done", int'(done), 0);

    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule